// File: doc/BRIEF.md
# Bounded Descending Stack Controller

This block keeps a last-in first-out store in a small fixed window of word addresses. A caller sends one request at a time, either a push carrying a data word or a pop, and some cycles later gets back a one-cycle completion pulse together with a pass/fail status bit. A successful pop also returns the word taken from the top of the stack.

The stack pointer moves toward lower addresses as the stack fills. The window spans five words, from 0x3FFF down to 0x3FFB. A pointer value of 0x4000 means the stack is empty. Before touching storage, the controller compares the pointer with the limit that applies to the request. A pop from an empty stack and a push into a full one are both refused, and neither changes the pointer or the stored words.

Top module: `stack_ctl`

## Requirements
- R1: Reset empties the stack (pointer 0x4000) and drives `rd_data` to 0, `done` to 0 and `fail` to 0. A pop issued right after a reset is refused, even if words were pushed before that reset.
- R2: A push first lowers the pointer by one and then writes the word at the new pointer. Words pushed are therefore returned by later pops in reverse order.
- R3: A pop first reads the word at the current pointer into `rd_data` and then raises the pointer by one. The next pop returns the word pushed before it.
- R4: A pop while the pointer is 0x4000 completes with `fail`=1. `rd_data` keeps its previous value and the stack stays empty.
- R5: A push while the pointer is 0x3FFB completes with `fail`=1. Nothing is written, and the five held words pop back unchanged.
- R6: A push or pop that is not refused completes with `fail`=0.
- R7: `done` is high for exactly one cycle per accepted request. It is seen 4 rising edges after the accepting edge (that edge counted as the first) for a request that is carried out, and 2 edges after it for a refused one. `fail` is meaningful only while `done` is high.
- R8: `req_valid` is sampled only while the controller is idle. Requests presented while one is in progress are ignored and produce no completion of their own.
- R9: The stack holds exactly five words: five pushes from empty succeed and the sixth is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_pop | input | 1 | 1 = pop, 0 = push |
| wr_data | input | 16 | Word to push, captured with the request |
| rd_data | output | 16 | Word returned by the last successful pop |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Status during `done`: 0 success, 1 underflow or overflow |

## Verification
The assertions assume that the caller holds `req_pop` and `wr_data` steady in the cycle where `req_valid` is sampled. They also assume that the stack pointer only ever moves through the controller's own sequencing, so it stays between 0x3FFB and 0x4000. The stimulus changes inputs only on falling edges. It waits for each completion before it issues the next request, except in the busy test, which holds `req_valid` high on purpose and flips the op and data while a push is in flight. The runs reach both limits, mix pushes and pops, and apply a reset while the stack is partly full.

// File: rtl/stack_ctl.sv
module stack_ctl #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] TOP_ADDR   = 'h3FFF,
  parameter logic [AW-1:0] LIMIT_ADDR = 'h3FFB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_pop,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          fail
);
  localparam logic [AW-1:0] EMPTY_ADDR = TOP_ADDR + 1'b1;
  localparam int DEPTH = int'(TOP_ADDR - LIMIT_ADDR) + 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_STEP1, S_STEP2, S_RESP} st_t;

  st_t           st;
  logic          op_pop;
  logic          fail_q;
  logic [DW-1:0] din_q;
  logic [AW-1:0] sp;
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic          at_empty, at_full, refuse;

  assign idx      = IW'(sp - LIMIT_ADDR);
  assign at_empty = (sp == EMPTY_ADDR);
  assign at_full  = (sp == LIMIT_ADDR);
  assign refuse   = op_pop ? at_empty : at_full;
  assign done     = (st == S_RESP);
  assign fail     = done & fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sp      <= EMPTY_ADDR;
      op_pop  <= 1'b0;
      fail_q  <= 1'b0;
      din_q   <= '0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_CHECK;
          op_pop <= req_pop;
          din_q  <= wr_data;
        end
        S_CHECK: begin
          fail_q <= refuse;
          st     <= refuse ? S_RESP : S_STEP1;
        end
        S_STEP1: begin
          if (op_pop) rd_data <= mem[idx];
          else        sp      <= sp - 1'b1;
          st <= S_STEP2;
        end
        S_STEP2: begin
          if (op_pop) sp <= sp + 1'b1;
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_STEP2 && !op_pop) mem[idx] <= din_q;
  end

  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP1 && !op_pop) |=> (sp == $past(sp) - 1'b1)); // R2
  AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP2 && op_pop) |=> (sp == $past(sp) + 1'b1)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && op_pop && at_empty) |=> (done && fail && $stable(sp) && $stable(rd_data))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && !op_pop && at_full) |=> (done && fail && $stable(sp))); // R5
  AST_OK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP2) |=> (done && !fail)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> (st != S_CHECK)); // R8
  AST_SP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sp >= LIMIT_ADDR && sp <= EMPTY_ADDR)); // R9
endmodule

// File: tb/stack_ctl_tb_top.sv
module stack_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_pop = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic done, fail;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stack_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pop(req_pop),
    .wr_data(wr_data), .rd_data(rd_data), .done(done), .fail(fail)
  );

  // {pop, wr_data, expected fail, expected rd_data (pops only)}
  localparam int NV = 18;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 16'h0000, 1'b1, 16'h0000},
    {1'b0, 16'h1111, 1'b0, 16'h0000},
    {1'b0, 16'h2222, 1'b0, 16'h0000},
    {1'b0, 16'h3333, 1'b0, 16'h0000},
    {1'b0, 16'h4444, 1'b0, 16'h0000},
    {1'b0, 16'h5555, 1'b0, 16'h0000},
    {1'b0, 16'h6666, 1'b1, 16'h0000},
    {1'b1, 16'h0000, 1'b0, 16'h5555},
    {1'b1, 16'h0000, 1'b0, 16'h4444},
    {1'b0, 16'h7777, 1'b0, 16'h0000},
    {1'b1, 16'h0000, 1'b0, 16'h7777},
    {1'b1, 16'h0000, 1'b0, 16'h3333},
    {1'b1, 16'h0000, 1'b0, 16'h2222},
    {1'b1, 16'h0000, 1'b0, 16'h1111},
    {1'b1, 16'h0000, 1'b1, 16'h1111},
    {1'b0, 16'h8888, 1'b0, 16'h0000},
    {1'b1, 16'h0000, 1'b0, 16'h8888},
    {1'b1, 16'h0000, 1'b1, 16'h8888}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic pop, input logic [15:0] d, output int lat,
                        output logic f, output logic [15:0] q, output logic single);
    @(negedge clk);
    req_valid = 1'b1; req_pop = pop; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    f = fail; q = rd_data;
    @(negedge clk);
    single = !done;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int lat, cnt;
    logic f, one;
    logic [15:0] q;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'd0, done}, 0);
    chk("R1 reset fail", {31'd0, fail}, 0);
    chk("R1 reset rd_data", {16'd0, rd_data}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      do_req(v[33], v[32:17], lat, f, q, one);
      chk(v[16] ? (v[33] ? "R4 underflow status" : "R5 overflow status") : "R6 ok status",
          {31'd0, f}, {31'd0, v[16]});
      chk("R7 latency", lat, v[16] ? 2 : 4);
      chk("R7 single pulse", {31'd0, one}, 1);
      if (v[33]) chk(v[16] ? "R4 rd_data held" : "R2 R3 lifo data", {16'd0, q}, {16'd0, v[15:0]});
    end

    // R9: exactly five fit
    for (int i = 0; i < 5; i++) begin
      do_req(1'b0, 16'hA000 + 16'(i), lat, f, q, one);
      chk("R9 push within capacity", {31'd0, f}, 0);
    end
    do_req(1'b0, 16'hBEEF, lat, f, q, one);
    chk("R9 sixth push refused", {31'd0, f}, 1);
    do_req(1'b1, 16'h0, lat, f, q, one);
    chk("R5 top word unchanged", {16'd0, q}, 32'h0000A004);

    // R1: reset while partly full
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears rd_data", {16'd0, rd_data}, 0);
    rst_n = 1'b1;
    do_req(1'b1, 16'h0, lat, f, q, one);
    chk("R1 pop after reset refused", {31'd0, f}, 1);

    // R8: requests while busy are ignored
    cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pop = 1'b0; wr_data = 16'hC0DE;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_pop = 1'b1; wr_data = 16'hDEAD;
      if (done) cnt++;
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done) cnt++;
      @(negedge clk);
    end
    chk("R8 one completion", cnt, 1);
    do_req(1'b1, 16'h0, lat, f, q, one);
    chk("R8 pushed word kept", {16'd0, q}, 32'h0000C0DE);
    do_req(1'b1, 16'h0, lat, f, q, one);
    chk("R8 no extra request", {31'd0, f}, 1);

    summary();
  end
endmodule